// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block produces the word-address stream for a multi-register load or store in a 32-bit core. A one-cycle start strobe captures a 16-bit register selection mask, a base address and four control bits: load/store, step-before/step-after, upward/downward and base update. The block then presents one transfer per selected register. Each transfer carries the register index, a word address and a load flag. A transfer holds until the consumer raises ready. After the last transfer is accepted, the block raises a one-cycle completion strobe. With that strobe it presents the updated base value and an update enable.

The same sequencer serves the stack forms. A full stack steps before each access and an empty stack steps after it. A descending stack moves downward on stores and upward on loads, and an ascending stack does the opposite. The caller maps these onto the step-before and upward bits. For example, a full-descending push is a store with step-before and downward, and the matching pop is a load with step-after and upward. Registers always leave in ascending index order, with the lowest index at the lowest address. In downward modes the walk therefore starts at the bottom of the block and climbs.

Top module: `mxfer_seq`

## Requirements
- R1: After reset, `xfer_valid_o`, `done_o` and `wb_en_o` are 0.
- R2: With upward=1, the first address is the base (step-after, pre_i=0) or the base plus 4 (step-before, pre_i=1).
- R3: With upward=0 and N selected registers, the first address is base−4N (step-before) or base−4N+4 (step-after). A full-descending push (pre_i=1, up_i=0, load_i=0) therefore stores its highest register at base−4.
- R4: Transfers are issued one per selected bit of `reg_list_i`, in ascending bit index. `xfer_idx_o` is the bit position, and each accepted transfer raises the next address by exactly 4.
- R5: `xfer_load_o` equals the `load_i` value captured at start for every transfer (1 = load, 0 = store).
- R6: During the completion strobe, `wb_value_o` is base+4N when upward=1 and base−4N when upward=0, whatever the value of pre_i. `wb_en_o` equals the captured `wback_i` and is high only with `done_o`.
- R7: An all-zero register list produces no transfer. `done_o` is high in the cycle after start, and `wb_value_o` equals the base.
- R8: While `xfer_valid_o` is high and `ready_i` is low, the index and address stay unchanged in the next cycle.
- R9: `done_o` rises in the cycle after the last transfer is accepted, lasts exactly one cycle, and is never high together with `xfer_valid_o`.
- R10: A start strobe, and changes on the mask, base or control inputs, while a sequence is running or completing have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a sequence (taken only when idle) |
| reg_list_i | input | 16 | Register selection mask, bit i = register i |
| base_i | input | 32 | Base address |
| load_i | input | 1 | 1 = load, 0 = store |
| pre_i | input | 1 | 1 = step before each access, 0 = step after |
| up_i | input | 1 | 1 = upward, 0 = downward |
| wback_i | input | 1 | Request base register update |
| ready_i | input | 1 | Consumer accepts the current transfer |
| xfer_valid_o | output | 1 | A transfer is presented |
| xfer_idx_o | output | 4 | Register index of the transfer |
| xfer_addr_o | output | 32 | Word address of the transfer |
| xfer_load_o | output | 1 | Transfer direction, 1 = load |
| done_o | output | 1 | One-cycle completion strobe |
| wb_en_o | output | 1 | Base update enable, only with done_o |
| wb_value_o | output | 32 | Updated base value, valid with done_o |

## Verification
Assertions check the cycle-level rules on every cycle: the hold under back-pressure, the step of four with rising index between accepted transfers, the single-cycle completion strobe that never overlaps a transfer, and completion right after start for an empty list. Only the bench scenarios can show the absolute values. These are the start address for each of the four step modes, the base update value, the captured load flag, and the fact that inputs changed mid-sequence are ignored. The bench compares all of these against values it computes itself, under random ready stalls.

// File: rtl/mxfer_pkg.sv
// Package: shared constants and types for the block transfer sequencer.
// Assumes word-sized transfers and a register list no wider than 32 bits.
package mxfer_pkg;

    // Sequencer states: waiting, issuing transfers, completion strobe.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/mxfer_popcnt.sv
// Module: counts the set bits of a mask with a generated chain of adders.
// Assumes CNT_W is wide enough to hold LIST_W.
module mxfer_popcnt #(
    parameter int LIST_W = 16,
    parameter int CNT_W  = $clog2(LIST_W + 1)
) (
    input  logic [LIST_W-1:0] mask_i,
    output logic [CNT_W-1:0]  count_o
);

    logic [CNT_W-1:0] partial [LIST_W+1];

    assign partial[0] = '0;

    // Running sum, one stage per mask bit.
    for (genvar g = 0; g < LIST_W; g++) begin : g_stage
        assign partial[g+1] = partial[g] + CNT_W'(mask_i[g]);
    end

    assign count_o = partial[LIST_W];

endmodule

// File: rtl/mxfer_addr_calc.sv
// Module: derives the first transfer address and the updated base value
// from the base, the transfer count and the step mode bits.
// Assumes addresses wrap modulo 2^ADDR_W; registers climb from the bottom.
module mxfer_addr_calc #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              pre_i,
    input  logic              up_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] update_o
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] bottom;

    // Byte span covered by the whole block of transfers.
    always_comb span = ADDR_W'(count_i) * STEP;

    // Lowest address of the block in the downward direction.
    always_comb bottom = base_i - span;

    // Start address for the four step modes.
    always_comb begin
        unique case ({up_i, pre_i})
            2'b11:   first_o = base_i + STEP;
            2'b10:   first_o = base_i;
            2'b01:   first_o = bottom;
            default: first_o = bottom + STEP;
        endcase
    end

    // Updated base depends on direction only.
    always_comb update_o = up_i ? (base_i + span) : bottom;

    // R6: the update always lies a full span away from the base.
    always_comb begin
        if (up_i) begin
            p_update_span_r6: assert (update_o - base_i == span);
        end else begin
            p_update_span_dn_r6: assert (base_i - update_o == span);
        end
    end

endmodule

// File: rtl/mxfer_pick.sv
// Module: selects the lowest set bit of the remaining mask and produces
// the mask with that bit cleared.
// Assumes IDX_W bits can encode any index below LIST_W.
module mxfer_pick #(
    parameter int LIST_W = 16,
    parameter int IDX_W  = $clog2(LIST_W)
) (
    input  logic [LIST_W-1:0] mask_i,
    output logic              any_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [LIST_W-1:0] rest_o
);

    logic [LIST_W-1:0] lowest;

    // Isolate the lowest set bit.
    always_comb lowest = mask_i & (~mask_i + LIST_W'(1));

    // Encode the isolated bit into an index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < LIST_W; i++) begin
            if (lowest[i]) idx_o = IDX_W'(i);
        end
    end

    // Remaining selections after the current one.
    always_comb rest_o = mask_i & ~lowest;

    // Presence of any selection.
    always_comb any_o = |mask_i;

    // R4: exactly one bit is removed per pick.
    always_comb begin
        if (any_o) begin
            p_one_removed_r4: assert ($countones(mask_i ^ rest_o) == 1);
        end
    end

endmodule

// File: rtl/mxfer_seq.sv
// Module: top of the block transfer address sequencer. Captures a request
// on start, issues one transfer per selected register in ascending index
// order under ready back-pressure, then pulses completion with the base
// update. Assumes start is honoured only while idle.
module mxfer_seq #(
    parameter int LIST_W     = 16,
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(LIST_W),
    localparam int CNT_W     = $clog2(LIST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LIST_W-1:0] reg_list_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              load_i,
    input  logic              pre_i,
    input  logic              up_i,
    input  logic              wback_i,
    input  logic              ready_i,
    output logic              xfer_valid_o,
    output logic [IDX_W-1:0]  xfer_idx_o,
    output logic [ADDR_W-1:0] xfer_addr_o,
    output logic              xfer_load_o,
    output logic              done_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_value_o
);

    import mxfer_pkg::*;

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    seq_state_t        state_q;
    logic [LIST_W-1:0] mask_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] update_q;
    logic              load_q;
    logic              wback_q;

    logic [CNT_W-1:0]  req_count;
    logic [ADDR_W-1:0] req_first;
    logic [ADDR_W-1:0] req_update;
    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [LIST_W-1:0] pick_rest;
    logic              accept_start;
    logic              accept_xfer;

    mxfer_popcnt #(
        .LIST_W (LIST_W),
        .CNT_W  (CNT_W)
    ) u_count (
        .mask_i  (reg_list_i),
        .count_o (req_count)
    );

    mxfer_addr_calc #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_calc (
        .base_i   (base_i),
        .count_i  (req_count),
        .pre_i    (pre_i),
        .up_i     (up_i),
        .first_o  (req_first),
        .update_o (req_update)
    );

    mxfer_pick #(
        .LIST_W (LIST_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .mask_i (mask_q),
        .any_o  (pick_any),
        .idx_o  (pick_idx),
        .rest_o (pick_rest)
    );

    // Handshake qualifiers for new requests and accepted transfers.
    always_comb accept_start = (state_q == SEQ_IDLE) && start_i;
    always_comb accept_xfer  = (state_q == SEQ_RUN) && ready_i;

    // Sequencer state and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            mask_q   <= '0;
            addr_q   <= '0;
            update_q <= '0;
            load_q   <= 1'b0;
            wback_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (accept_start) begin
                        mask_q   <= reg_list_i;
                        addr_q   <= req_first;
                        update_q <= req_update;
                        load_q   <= load_i;
                        wback_q  <= wback_i;
                        state_q  <= (reg_list_i == '0) ? SEQ_FIN : SEQ_RUN;
                    end
                end
                SEQ_RUN: begin
                    if (accept_xfer) begin
                        mask_q <= pick_rest;
                        addr_q <= addr_q + STEP;
                        if (pick_rest == '0) state_q <= SEQ_FIN;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output drive from the registered state.
    always_comb begin
        xfer_valid_o = (state_q == SEQ_RUN);
        xfer_idx_o   = pick_idx;
        xfer_addr_o  = addr_q;
        xfer_load_o  = load_q;
        done_o       = (state_q == SEQ_FIN);
        wb_en_o      = done_o && wback_q;
        wb_value_o   = update_q;
    end

    // R8: a stalled transfer holds its index and address.
    p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && !ready_i) |=> (xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_idx_o)));

    // R4: the next transfer after an accepted one sits one word higher.
    p_step_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && ready_i) |=> (!xfer_valid_o || (xfer_addr_o == $past(xfer_addr_o) + STEP)));

    // R4: the register index rises between transfers.
    p_idx_rises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && ready_i) |=> (!xfer_valid_o || (xfer_idx_o > $past(xfer_idx_o))));

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: completion never overlaps a transfer.
    p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && xfer_valid_o));

    // R6: the update enable only accompanies completion.
    p_wb_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> done_o);

    // R7: an empty list completes in the next cycle.
    p_empty_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_start && (reg_list_i == '0)) |=> (done_o && !xfer_valid_o));

    // R10: a running sequence keeps its direction flag.
    p_load_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid_o && $past(xfer_valid_o)) |-> $stable(xfer_load_o));

    // R4: a running sequence always has a selection left.
    p_run_has_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid_o |-> pick_any);

endmodule

// File: tb/tb_mxfer_seq.sv
module tb_mxfer_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reg_list_i = '0;
    logic [31:0] base_i = '0;
    logic        load_i = 1'b0;
    logic        pre_i = 1'b0;
    logic        up_i = 1'b0;
    logic        wback_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        xfer_valid_o;
    logic [3:0]  xfer_idx_o;
    logic [31:0] xfer_addr_o;
    logic        xfer_load_o;
    logic        done_o;
    logic        wb_en_o;
    logic [31:0] wb_value_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    mxfer_seq dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .reg_list_i   (reg_list_i),
        .base_i       (base_i),
        .load_i       (load_i),
        .pre_i        (pre_i),
        .up_i         (up_i),
        .wback_i      (wback_i),
        .ready_i      (ready_i),
        .xfer_valid_o (xfer_valid_o),
        .xfer_idx_o   (xfer_idx_o),
        .xfer_addr_o  (xfer_addr_o),
        .xfer_load_o  (xfer_load_o),
        .done_o       (done_o),
        .wb_en_o      (wb_en_o),
        .wb_value_o   (wb_value_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [31:0] exp_first(input logic [31:0] b, input int n,
                                              input logic p, input logic u);
        if (u) return p ? b + 32'd4 : b;
        return p ? b - 32'(4*n) : b - 32'(4*n) + 32'd4;
    endfunction

    function automatic logic [31:0] exp_update(input logic [31:0] b, input int n, input logic u);
        return u ? b + 32'(4*n) : b - 32'(4*n);
    endfunction

    // One complete sequence, checked cycle by cycle at the falling edge.
    task automatic run_case(input logic [15:0] lst, input logic [31:0] b, input logic l,
                            input logic p, input logic u, input logic w, input bit noise);
        int n;
        logic [31:0] a;
        bit first;
        bit rdy;
        n = popc(lst);
        a = exp_first(b, n, p, u);
        reg_list_i = lst; base_i = b; load_i = l; pre_i = p; up_i = u; wback_i = w;
        start_i = 1'b1;
        ready_i = 1'b0;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        // Scramble the request inputs: the captured request must prevail (R10).
        reg_list_i = 16'($urandom); base_i = $urandom; load_i = ~l; up_i = ~u; pre_i = ~p; wback_i = ~w;
        if (n == 0) begin
            chk("R7 no transfer", 32'(xfer_valid_o), 32'd0);
        end
        first = 1'b1;
        for (int i = 0; i < 16; i++) begin
            if (lst[i]) begin
                rdy = 1'b0;
                while (!rdy) begin
                    chk("R4 valid", 32'(xfer_valid_o), 32'd1);
                    chk("R4 index order", 32'(xfer_idx_o), 32'(i));
                    if (first) chk(u ? "R2 first addr" : "R3 first addr", xfer_addr_o, a);
                    else       chk("R4/R8 addr", xfer_addr_o, a);
                    chk("R5 load flag", 32'(xfer_load_o), 32'(l));
                    chk("R9 no done mid-run", 32'(done_o), 32'd0);
                    rdy = ($urandom % 3) != 0;
                    ready_i = rdy;
                    if (!rdy && noise) begin
                        start_i = 1'b1;   // R10: ignored while running
                        base_i = $urandom;
                        reg_list_i = 16'($urandom);
                    end
                    @(posedge clk); @(negedge clk);
                    start_i = 1'b0;
                end
                first = 1'b0;
                a = a + 32'd4;
            end
        end
        ready_i = 1'b0;
        chk(n == 0 ? "R7 done" : "R9 done", 32'(done_o), 32'd1);
        chk("R9 no valid at done", 32'(xfer_valid_o), 32'd0);
        chk("R6 wb enable", 32'(wb_en_o), 32'(w));
        chk(n == 0 ? "R7 base kept" : "R6 wb value", wb_value_o, exp_update(b, n, u));
        start_i = 1'b1;   // R10: ignored during completion
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        chk("R9 done one cycle", 32'(done_o), 32'd0);
        chk("R10 idle after done", 32'(xfer_valid_o), 32'd0);
        chk("R6 wb enable low", 32'(wb_en_o), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 valid reset", 32'(xfer_valid_o), 32'd0);
        chk("R1 done reset", 32'(done_o), 32'd0);
        chk("R1 wb_en reset", 32'(wb_en_o), 32'd0);

        // Directed cases covering each step mode and stack form.
        run_case(16'h00F0, 32'h0000_1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // step-after up
        run_case(16'h8421, 32'h0000_2000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0); // step-before up
        run_case(16'h4030, 32'h0000_3000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // full-descending push
        run_case(16'h4030, 32'h0000_2FF4, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // matching pop
        run_case(16'h0006, 32'h0000_4000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // step-after down
        run_case(16'h0000, 32'hDEAD_BEE0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // empty list
        run_case(16'hFFFF, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1); // all registers
        run_case(16'h0007, 32'h0000_0008, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1); // wraps below zero
        run_case(16'h8000, 32'hFFFF_FFFC, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); // wraps above top

        // Random requests with stalls and injected noise.
        for (int k = 0; k < 80; k++) begin
            run_case(16'($urandom), {$urandom} & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
                     1'($urandom), 1'($urandom), 1'b1);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule